// File: doc/BRIEF.md
# Serial Clock-Buffer Configuration Slave

This block is the configuration side of a multi-output clock buffer. A bus master writes it over a two-wire serial bus (SCL clock, SDA open-drain data), and it never answers reads. The block samples both bus lines with a fast system clock. It finds START and STOP conditions, shifts in bytes most significant bit first, and pulls SDA low to acknowledge. It accepts only one rigid frame of ten bytes:

1. The device address byte `8'hD2`, which is the 7-bit address `1101001` followed by a write bit of 0.
2. A command byte.
3. A count byte.
4. Seven data bytes.

The command and count bytes are clocked through and acknowledged, but their values are discarded. Data bytes 0 to 6 land in enable registers 0 to 6, in that order.

The enable registers gate the buffered clock outputs. Output `8*k+b` belongs to register `k`, bit `b`. An output drives when the global `out_en` pin is 1 and its own register bit is 1; otherwise it is released. While driven, the output follows `ref_clk`. While released, the enable is low and the data pin rests at 0. The pad logic turns the enable into a high-impedance state. Reset loads every register with `8'hFF`, so out of reset only `out_en` decides whether the outputs drive.

The receiver is a five-state machine:

- `ST_IDLE`: waits for START.
- `ST_SHIFT`: collects eight bits on SCL rising edges.
- `ST_DECIDE`: waits for the SCL falling edge after the eighth bit and chooses between acknowledging and skipping.
- `ST_ACK`: pulls SDA low through the ninth SCL period.
- `ST_SKIP`: stays silent until the next START or STOP.

Its transitions are:

- START from any state goes to `ST_SHIFT` and clears the bit and byte counters.
- STOP from any state goes to `ST_IDLE`.
- `ST_SHIFT` goes to `ST_DECIDE` on the eighth rising edge.
- `ST_DECIDE` goes to `ST_ACK` on the falling edge when the byte is accepted, and to `ST_SKIP` when it is not.
- `ST_ACK` goes back to `ST_SHIFT` on the next falling edge.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: After reset all seven enable registers hold `8'hFF`, so with `out_en` = 1 every bit of `clk_oe` is 1.
- R2: While `out_en` is 0, every bit of `clk_oe` and of `clk_out` is 0, whatever the registers hold.
- R3: `clk_oe[8*k+b]` equals `out_en` AND bit `b` of register `k`. A driven output equals `ref_clk`, and a released output is 0.
- R4: After START, a first byte of exactly `8'hD2` begins a frame in which data bytes 0 to 6 (frame bytes 4 to 10) are stored in registers 0 to 6 in that order.
- R5: A first byte other than `8'hD2`, including the read form `8'hD3`, is not acknowledged. That byte and every byte after it, up to the next START or STOP, leave all registers unchanged.
- R6: The command byte (frame byte 2) and the count byte (frame byte 3) are acknowledged but change no register. Their values, the count included, do not move where the data bytes land.
- R7: The slave sets `sda_pull` = 1 during the ninth SCL period of the matching address and of frame bytes 2 to 10. It leaves `sda_pull` = 0 for an eleventh byte.
- R8: A STOP before the frame completes keeps the registers already written and leaves the rest unchanged.
- R9: A START in the middle of a frame restarts it: the next byte is again checked as the address byte, and the next data byte goes to register 0.
- R10: Bits are taken most significant bit first on SCL rising edges. `sda_pull` changes only while SCL is low.
- R11: A register changes only in a cycle where `sda_pull` is asserted, meaning each data byte is committed at its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line, as seen on the wire |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be buffered |
| out_en | input | 1 | Global output enable |
| clk_out | output | 56 | Buffered clock outputs |
| clk_oe | output | 56 | Per-output drive enable; 0 = high-impedance |

## Verification
The bench checks for each of these corner cases that a wrong design shows itself at the ports:

- Address acceptance. Near-miss addresses, including the read bit set on the right 7-bit address, are sent. A design that compares only seven bits, or that acknowledges anyway, would write registers or pull SDA on a foreign frame.
- Ignored header bytes. Frames carry a nonzero command and a count byte of 2. A design that honoured the count, or stored the command, would shift the data into the wrong registers or stop early.
- Frame interruptions. A frame is cut off by an early STOP and another by a repeated START. Each exposes a byte counter that is not cleared or writes that are not committed per byte.
- Eleventh byte. It must not be acknowledged, which catches an off-by-one frame length.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    // Fixed frame layout: address, command, count, then data bytes
    localparam int HDR_BYTES = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_DECIDE = 3'd2,
        ST_ACK    = 3'd3,
        ST_SKIP   = 3'd4
    } rx_state_e;

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        sda_bit   = sda_s;
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/cfg_byte_fsm.sv
module cfg_byte_fsm
    import clkcfg_pkg::*;
#(
    parameter int         REG_COUNT = 7,
    parameter int         BYTE_W    = 8,
    parameter logic [7:0] DEV_ADDR  = 8'hD2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_bit,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    output logic                 ack_drive,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [BYTE_W-1:0]    wr_data
);

    localparam int FRAME_BYTES = HDR_BYTES + REG_COUNT;
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
    localparam int BIT_W       = $clog2(BYTE_W);
    localparam int IDX_W       = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    rx_state_e             state_q;
    rx_state_e             state_nx;
    logic [BYTE_W-1:0]     shreg_q;
    logic [BIT_W-1:0]      bit_cnt_q;
    logic [CNT_W-1:0]      byte_idx_q;
    logic                  bit_last;
    logic                  accept;
    logic                  is_data;

    assign bit_last = (bit_cnt_q == BIT_W'(BYTE_W - 1));
    assign is_data  = (byte_idx_q >= CNT_W'(HDR_BYTES));

    always_comb begin
        if (byte_idx_q == '0) begin
            accept = (shreg_q == BYTE_W'(DEV_ADDR));
        end else begin
            accept = (byte_idx_q < CNT_W'(FRAME_BYTES));
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (start_det) begin
            state_nx = ST_SHIFT;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_nx = ST_IDLE;
                ST_SHIFT: begin
                    if (scl_rise && bit_last) state_nx = ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (scl_fall) state_nx = accept ? ST_ACK : ST_SKIP;
                end
                ST_ACK: begin
                    if (scl_fall) state_nx = ST_SHIFT;
                end
                ST_SKIP: state_nx = ST_SKIP;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Bit and byte bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
        end else if (start_det) begin
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
        end else if (!stop_det) begin
            if (state_q == ST_SHIFT && scl_rise) begin
                shreg_q   <= {shreg_q[BYTE_W-2:0], sda_bit};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (state_q == ST_ACK && scl_fall) begin
                bit_cnt_q  <= '0;
                byte_idx_q <= byte_idx_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ack_drive = (state_q == ST_ACK);
        wr_en     = (state_q == ST_DECIDE) && scl_fall && !start_det &&
                    !stop_det && accept && is_data;
        wr_idx    = IDX_W'(byte_idx_q - CNT_W'(HDR_BYTES));
        wr_data   = shreg_q;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int                REG_COUNT = 7,
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] RESET_VAL = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [REG_COUNT*BYTE_W-1:0] en_bits
);

    localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    generate
        for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
            logic [BYTE_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= RESET_VAL;
                end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                    val_q <= wr_data;
                end
            end
            assign en_bits[k*BYTE_W +: BYTE_W] = val_q;
        end
    endgenerate

endmodule

// File: rtl/clk_gate_array.sv
module clk_gate_array #(
    parameter int NUM_OUT = 56
) (
    input  logic               ref_clk,
    input  logic               out_en,
    input  logic [NUM_OUT-1:0] en_bits,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_oe
);

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            assign clk_oe[i]  = out_en & en_bits[i];
            assign clk_out[i] = clk_oe[i] & ref_clk;
        end
    endgenerate

endmodule

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave #(
    parameter int         REG_COUNT   = 7,
    parameter int         BYTE_W      = 8,
    parameter logic [7:0] DEV_ADDR    = 8'hD2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_in,
    input  logic                        sda_in,
    output logic                        sda_pull,
    input  logic                        ref_clk,
    input  logic                        out_en,
    output logic [REG_COUNT*BYTE_W-1:0] clk_out,
    output logic [REG_COUNT*BYTE_W-1:0] clk_oe
);

    localparam int NUM_OUT = REG_COUNT * BYTE_W;
    localparam int IDX_W   = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    logic               sda_bit;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [BYTE_W-1:0]  wr_data;
    logic [NUM_OUT-1:0] en_bits;

    cfg_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_byte_fsm #(
        .REG_COUNT (REG_COUNT),
        .BYTE_W    (BYTE_W),
        .DEV_ADDR  (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_drive (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfg_reg_bank #(
        .REG_COUNT (REG_COUNT),
        .BYTE_W    (BYTE_W),
        .RESET_VAL ('1)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .en_bits (en_bits)
    );

    clk_gate_array #(
        .NUM_OUT (NUM_OUT)
    ) u_gate (
        .ref_clk (ref_clk),
        .out_en  (out_en),
        .en_bits (en_bits),
        .clk_out (clk_out),
        .clk_oe  (clk_oe)
    );

endmodule

// File: rtl/clkbuf_cfg_slave_chk.sv
module clkbuf_cfg_slave_chk #(
    parameter int NUM_OUT = 56
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_in,
    input logic               sda_pull,
    input logic               ref_clk,
    input logic               out_en,
    input logic [NUM_OUT-1:0] clk_out,
    input logic [NUM_OUT-1:0] clk_oe
);

    // R10
    ack_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_in);

    // R2
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (clk_oe == '0 && clk_out == '0));

    // R3
    released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out & ~clk_oe) == '0);

    // R3
    driven_follows_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_out ^ {NUM_OUT{ref_clk}}) & clk_oe) == '0);

    // R11
    commit_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en == $past(out_en) && clk_oe != $past(clk_oe)) |-> sda_pull);

endmodule

bind clkbuf_cfg_slave clkbuf_cfg_slave_chk #(
    .NUM_OUT (REG_COUNT * BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_pull (sda_pull),
    .ref_clk  (ref_clk),
    .out_en   (out_en),
    .clk_out  (clk_out),
    .clk_oe   (clk_oe)
);

// File: tb/test_clkbuf_cfg_slave.sv
module test_clkbuf_cfg_slave;

    localparam int NREG = 7;
    localparam int NOUT = NREG * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_scl = 1'b1;
    logic            m_sda = 1'b1;
    logic            ref_clk = 1'b0;
    logic            out_en = 1'b1;
    logic            sda_pull;
    logic [NOUT-1:0] clk_out;
    logic [NOUT-1:0] clk_oe;
    logic            sda_line;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_reg [NREG];
    bit         ack_q [$];
    string      ack_tag_q [$];
    event       ack_ev;

    assign sda_line = m_sda & ~sda_pull;

    always #5 clk = ~clk;
    always #15 ref_clk = ~ref_clk;

    clkbuf_cfg_slave i_clkbuf_cfg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .ref_clk  (ref_clk),
        .out_en   (out_en),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NOUT-1:0] exp_bits();
        logic [NOUT-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_reg[k];
        return v;
    endfunction

    // Monitor: pops the expected acknowledge for each ninth SCL period
    initial begin
        forever begin
            @(ack_ev);
            if (ack_q.size() == 0) begin
                check(1'b0, "R7 unexpected ack slot", 64'(sda_pull), 64'd0);
            end else begin
                bit    e;
                string t;
                e = ack_q.pop_front();
                t = ack_tag_q.pop_front();
                check(sda_pull == e, t, 64'(sda_pull), 64'(e));
            end
        end
    end

    task automatic do_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0;
    endtask

    task automatic do_restart();
        tick(6); m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(6); m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    // Driver: R10 bits go out MSB first, SDA changed only while SCL is low
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        ack_q.push_back(exp_ack);
        ack_tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            tick(6); m_sda = b[i]; tick(4);
            m_scl = 1'b1; tick(8);
            m_scl = 1'b0;
        end
        tick(6); m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(4);
        -> ack_ev;
        tick(4);
        m_scl = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        tick(4);
        check(clk_oe == exp_bits(), tag, 64'(clk_oe), 64'(exp_bits()));
    endtask

    task automatic check_ref(input string tag);
        @(negedge clk);
        check(clk_out == (clk_oe & {NOUT{ref_clk}}), tag, 64'(clk_out),
              64'(clk_oe & {NOUT{ref_clk}}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [NREG];
        for (int k = 0; k < NREG; k++) exp_reg[k] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        check(clk_oe == {NOUT{1'b1}}, "R1 reset enables", 64'(clk_oe), 64'(exp_bits()));
        check(sda_pull == 1'b0, "R1 idle no pull", 64'(sda_pull), 64'd0);

        // R2: global disable
        out_en = 1'b0; tick(2);
        check(clk_oe == '0, "R2 oe low", 64'(clk_oe), 64'd0);
        check(clk_out == '0, "R2 out low", 64'(clk_out), 64'd0);
        out_en = 1'b1; tick(2);

        // R4 R6 R7 R10: full frame, command and count ignored
        d = '{8'h81, 8'h42, 8'h24, 8'h18, 8'hA5, 8'h5A, 8'h0F};
        do_start();
        send_byte(8'hD2, 1'b1, "R7 address ack");
        send_byte(8'h55, 1'b1, "R6 command ack");
        send_byte(8'h00, 1'b1, "R6 count ack");
        for (int k = 0; k < NREG; k++) begin
            send_byte(d[k], 1'b1, "R7 data ack");
            exp_reg[k] = d[k];
        end
        do_stop();
        check_regs("R4 R10 full frame");

        // R3: outputs follow ref_clk where enabled
        check_ref("R3 ref follow phase a");
        tick(2);
        check_ref("R3 ref follow phase b");
        out_en = 1'b0; tick(1);
        check(clk_oe == '0, "R2 disable over regs", 64'(clk_oe), 64'd0);
        out_en = 1'b1; tick(2);

        // R6 R7: count byte of 2 must not shorten the frame; 11th byte not acked
        d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
        do_start();
        send_byte(8'hD2, 1'b1, "R7 address ack 2");
        send_byte(8'hFF, 1'b1, "R6 command ack 2");
        send_byte(8'h02, 1'b1, "R6 count ack 2");
        for (int k = 0; k < NREG; k++) begin
            send_byte(d[k], 1'b1, "R6 data ack past count");
            exp_reg[k] = d[k];
        end
        send_byte(8'h00, 1'b0, "R7 eleventh byte nack");
        do_stop();
        check_regs("R6 count ignored");

        // R5: wrong address
        do_start();
        send_byte(8'hA4, 1'b0, "R5 wrong addr nack");
        send_byte(8'h00, 1'b0, "R5 skip byte 2");
        send_byte(8'h00, 1'b0, "R5 skip byte 3");
        send_byte(8'h00, 1'b0, "R5 skip data");
        do_stop();
        check_regs("R5 wrong addr no change");

        // R5: read form of right address
        do_start();
        send_byte(8'hD3, 1'b0, "R5 read addr nack");
        send_byte(8'h00, 1'b0, "R5 read skip 2");
        send_byte(8'h00, 1'b0, "R5 read skip 3");
        send_byte(8'h00, 1'b0, "R5 read skip data");
        do_stop();
        check_regs("R5 read addr no change");

        // R8: early stop after two data bytes
        do_start();
        send_byte(8'hD2, 1'b1, "R8 addr ack");
        send_byte(8'h00, 1'b1, "R8 cmd ack");
        send_byte(8'h07, 1'b1, "R8 cnt ack");
        send_byte(8'hC3, 1'b1, "R8 data0 ack"); exp_reg[0] = 8'hC3;
        send_byte(8'h3C, 1'b1, "R8 data1 ack"); exp_reg[1] = 8'h3C;
        do_stop();
        check_regs("R8 early stop partial");

        // R9: repeated start restarts the frame
        do_start();
        send_byte(8'hD2, 1'b1, "R9 addr ack");
        send_byte(8'h00, 1'b1, "R9 cmd ack");
        send_byte(8'h00, 1'b1, "R9 cnt ack");
        send_byte(8'h99, 1'b1, "R9 data0 first"); exp_reg[0] = 8'h99;
        do_restart();
        send_byte(8'hD2, 1'b1, "R9 addr ack again");
        send_byte(8'h01, 1'b1, "R9 cmd ack again");
        send_byte(8'h01, 1'b1, "R9 cnt ack again");
        send_byte(8'hE1, 1'b1, "R9 data0 again"); exp_reg[0] = 8'hE1;
        send_byte(8'hE2, 1'b1, "R9 data1 again"); exp_reg[1] = 8'hE2;
        send_byte(8'hE3, 1'b1, "R9 data2 again"); exp_reg[2] = 8'hE3;
        do_stop();
        check_regs("R9 restart realigns");

        // R9: restart into a wrong address blocks the rest
        do_start();
        send_byte(8'hD2, 1'b1, "R9 addr before bad restart");
        do_restart();
        send_byte(8'h52, 1'b0, "R9 bad addr after restart");
        send_byte(8'h00, 1'b0, "R9 skip after restart");
        do_stop();
        check_regs("R9 bad restart no change");
        check_ref("R3 ref follow final");

        tick(10);
        check(ack_q.size() == 0, "R7 all ack slots seen", 64'(ack_q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule